// File: doc/BRIEF.md
# Multi-Source Interrupt Aggregator

The aggregator collects eight interrupt sources of a bus-attached expander into one interrupt pin. Seven of the sources are short event pulses. An event is latched into a pending flag if its source is enabled, and software clears the flag by writing ones to an acknowledge location. The eighth source, the general-purpose I/O source in bit 0, is not latched at all. It is the live OR of 24 per-pin pending flags, arranged as three 8-bit banks. Those flags are cleared elsewhere, so the acknowledge register has no effect on this bit.

Software reaches the block through a byte-wide register bus. Writes take effect at the clock edge. Read data is a combinational function of the address. The interrupt pin has its own configuration. It can be open-drain, in which case it is driven only while asserted, or push-pull, in which case it is always driven. Its active level can be high or low. The block exposes the pin as a data bit and an output-enable bit.

Top module: `irq_hub`

## Requirements
- R1: After reset, the source-enable register, the pin configuration and every latched flag are 0. The pin is therefore open-drain and active-low, and `irq_pin_oe_o` is 0.
- R2: The register map is as follows. Address 0x41 holds the pin configuration in bits [1:0] and reads 0 in the upper bits. Address 0x42 holds the 8-bit source enable. Address 0x44 is the write-only acknowledge and reads 0. Any address outside the map reads 0, and writes to it change nothing.
- R3: A pulse on `src_evt_i[k]` (k = 1..7) in a cycle where enable bit k is 1 sets pending bit k. The bit is visible at read address 0x08 in the next cycle and stays set until it is acknowledged or its source is disabled.
- R4: An event on a source whose enable bit is 0 sets nothing. Clearing an enable bit drops that source's latched flag one cycle later.
- R5: Writing 0x44 with bit k = 1 (k = 1..7) clears pending bit k in the next cycle. Bits written as 0 keep their state.
- R6: Pending bit 0 is enable bit 0 ANDed with the OR of the 24 `gpio_flag_i` bits, and it follows those bits in the same cycle. Acknowledging bit 0 has no effect. Addresses 0x0C, 0x0D and 0x0E read back flag bits [7:0], [15:8] and [23:16].
- R7: If an enabled event and its acknowledge arrive in the same cycle, the event wins and the pending bit stays set.
- R8: The interrupt is active while any pending bit reads 1. Configuration bit 1 sets the pin level: with bit 1 = 1, `irq_pin_o` is high when active; with bit 1 = 0, it is low when active.
- R9: Configuration bit 0 sets the drive type. With bit 0 = 1 (push-pull), `irq_pin_oe_o` is always 1. With bit 0 = 0 (open-drain), `irq_pin_oe_o` equals the active state.
- R10: Address 0x08 is read-only. Writing it changes no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| src_evt_i | input | 7 | Event pulses for sources 7..1 (bit index = source number) |
| gpio_flag_i | input | 24 | Per-pin pending flags, bank 0 in bits [7:0] |
| irq_pin_o | output | 1 | Interrupt pin data |
| irq_pin_oe_o | output | 1 | Interrupt pin output enable |

## Verification
Register writes, events and acknowledges act at the next clock edge. Their results, on the pending readback and on the pin, are therefore due one cycle after the stimulus. GPIO flag changes and address changes reach `reg_rdata` and the pin in the same cycle, with no register in the path. The bench drives inputs 2 ns after the rising edge and updates its reference model on the rising edge. It compares every output at the falling edge, so each compare sees exactly the state produced by the last edge. Directed checks read 1 ns after the inputs settle, again away from any edge.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

   // Decoded addresses (fixed by the software map)
   localparam logic [7:0] ADR_PEND   = 8'h08;
   localparam logic [7:0] ADR_GPF0   = 8'h0C;
   localparam logic [7:0] ADR_PINCFG = 8'h41;
   localparam logic [7:0] ADR_SRCEN  = 8'h42;
   localparam logic [7:0] ADR_ACK    = 8'h44;

   // Source numbering; the order is the bit order of every source vector
   typedef enum logic [2:0] {
      SRC_GPIO   = 3'd0,
      SRC_METER  = 3'd1,
      SRC_FAULT  = 3'd2,
      SRC_TDET   = 3'd3,
      SRC_TNEMP  = 3'd4,
      SRC_TTHR   = 3'd5,
      SRC_TFULL  = 3'd6,
      SRC_TOVF   = 3'd7
   } src_e;

   // Pin configuration, bit 1 = level, bit 0 = drive type
   typedef struct packed {
      logic active_high;
      logic push_pull;
   } pin_cfg_t;

endpackage

// File: rtl/irq_hub_regs.sv
module irq_hub_regs
   import irq_hub_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned N_SRC      = 8,
   parameter int unsigned GPIO_BANKS = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr,
   input  logic [ADDR_W-1:0]            addr,
   input  logic [DATA_W-1:0]            wdata,
   input  logic [N_SRC-1:0]             pend_vis,
   input  logic [GPIO_BANKS*DATA_W-1:0] gpio_flag,
   output logic [DATA_W-1:0]            rdata,
   output logic [N_SRC-1:0]             src_en,
   output pin_cfg_t                     pin_cfg,
   output logic [N_SRC-1:1]             ack
);

   localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(ADR_PEND);
   localparam logic [ADDR_W-1:0] A_PINCFG = ADDR_W'(ADR_PINCFG);
   localparam logic [ADDR_W-1:0] A_SRCEN  = ADDR_W'(ADR_SRCEN);
   localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(ADR_ACK);

   logic hit_cfg, hit_en, hit_ack;
   assign hit_cfg = wr && (addr == A_PINCFG);
   assign hit_en  = wr && (addr == A_SRCEN);
   assign hit_ack = wr && (addr == A_ACK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_en  <= '0;
         pin_cfg <= '0;
      end else begin
         if (hit_en)  src_en  <= wdata[N_SRC-1:0];
         if (hit_cfg) pin_cfg <= pin_cfg_t'(wdata[1:0]);
      end
   end

   // Acknowledge is a one-cycle strobe, bit 0 (live source) has none
   assign ack = hit_ack ? wdata[N_SRC-1:1] : '0;

   // Per-bank readback decode
   logic [GPIO_BANKS-1:0] bank_hit;
   logic [DATA_W-1:0]     bank_data;

   for (genvar b = 0; b < GPIO_BANKS; b++) begin : g_bank
      assign bank_hit[b] = (addr == ADDR_W'(int'(ADR_GPF0) + b));
   end

   always_comb begin
      bank_data = '0;
      for (int b = 0; b < int'(GPIO_BANKS); b++) begin
         if (bank_hit[b]) bank_data = gpio_flag[b*DATA_W +: DATA_W];
      end
   end

   always_comb begin
      unique case (addr)
         A_PEND:   rdata = DATA_W'(pend_vis);
         A_PINCFG: rdata = DATA_W'(pin_cfg);
         A_SRCEN:  rdata = DATA_W'(src_en);
         default:  rdata = bank_data;
      endcase
   end

endmodule

// File: rtl/irq_hub_pending.sv
module irq_hub_pending #(
   parameter int unsigned N_SRC      = 8,
   parameter int unsigned BANK_W     = 8,
   parameter int unsigned GPIO_BANKS = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [N_SRC-1:1]             evt,
   input  logic [N_SRC-1:0]             src_en,
   input  logic [N_SRC-1:1]             ack,
   input  logic [GPIO_BANKS*BANK_W-1:0] gpio_flag,
   output logic [N_SRC-1:1]             latched,
   output logic [N_SRC-1:0]             pend_vis
);

   // Live source: reduce each bank, then the banks
   logic [GPIO_BANKS-1:0] bank_any;
   for (genvar b = 0; b < GPIO_BANKS; b++) begin : g_red
      assign bank_any[b] = |gpio_flag[b*BANK_W +: BANK_W];
   end
   assign pend_vis[0] = src_en[0] & (|bank_any);

   // Latched sources: event sets, acknowledge clears, event wins a tie,
   // a disabled source neither sets nor holds
   for (genvar k = 1; k < N_SRC; k++) begin : g_lat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          latched[k] <= 1'b0;
         else if (!src_en[k]) latched[k] <= 1'b0;
         else if (evt[k])     latched[k] <= 1'b1;
         else if (ack[k])     latched[k] <= 1'b0;
      end
      assign pend_vis[k] = latched[k] & src_en[k];
   end

endmodule

// File: rtl/irq_hub_pin.sv
module irq_hub_pin
   import irq_hub_pkg::*;
#(
   parameter int unsigned N_SRC = 8
) (
   input  logic [N_SRC-1:0] pend_vis,
   input  pin_cfg_t         cfg,
   output logic             pin,
   output logic             pin_oe
);

   logic active;
   assign active = |pend_vis;
   assign pin    = cfg.active_high ? active : ~active;
   assign pin_oe = cfg.push_pull | active;

endmodule

// File: rtl/irq_hub.sv
module irq_hub
   import irq_hub_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned N_SRC      = 8,
   parameter int unsigned GPIO_BANKS = 3,
   localparam int unsigned GPIO_W    = GPIO_BANKS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [N_SRC-1:1]  src_evt_i,
   input  logic [GPIO_W-1:0] gpio_flag_i,
   output logic              irq_pin_o,
   output logic              irq_pin_oe_o
);

   if (ADDR_W < 8) begin : g_chk_aw
      $error("irq_hub: ADDR_W must reach the 8-bit map");
   end
   if (N_SRC < 2 || N_SRC > DATA_W) begin : g_chk_src
      $error("irq_hub: N_SRC must lie in 2..DATA_W");
   end
   if (GPIO_BANKS < 1 || GPIO_BANKS > 4) begin : g_chk_bank
      $error("irq_hub: GPIO_BANKS must lie in 1..4");
   end

   logic [N_SRC-1:0] src_en;
   pin_cfg_t         pin_cfg;
   logic [N_SRC-1:1] ack;
   logic [N_SRC-1:1] latched;
   logic [N_SRC-1:0] pend_vis;

   irq_hub_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SRC(N_SRC), .GPIO_BANKS(GPIO_BANKS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .pend_vis(pend_vis), .gpio_flag(gpio_flag_i), .rdata(reg_rdata),
      .src_en(src_en), .pin_cfg(pin_cfg), .ack(ack)
   );

   irq_hub_pending #(
      .N_SRC(N_SRC), .BANK_W(DATA_W), .GPIO_BANKS(GPIO_BANKS)
   ) u_pend (
      .clk(clk), .rst_n(rst_n), .evt(src_evt_i), .src_en(src_en), .ack(ack),
      .gpio_flag(gpio_flag_i), .latched(latched), .pend_vis(pend_vis)
   );

   irq_hub_pin #(.N_SRC(N_SRC)) u_pin (
      .pend_vis(pend_vis), .cfg(pin_cfg), .pin(irq_pin_o), .pin_oe(irq_pin_oe_o)
   );

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned N_SRC      = 8,
   parameter int unsigned GPIO_BANKS = 3
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         reg_wr,
   input logic [ADDR_W-1:0]            reg_addr,
   input logic [DATA_W-1:0]            reg_wdata,
   input logic [N_SRC-1:1]             src_evt_i,
   input logic [GPIO_BANKS*DATA_W-1:0] gpio_flag_i,
   input logic [N_SRC-1:0]             src_en,
   input logic [1:0]                   pin_cfg,
   input logic [N_SRC-1:1]             latched,
   input logic                         irq_pin_o,
   input logic                         irq_pin_oe_o
);

   logic                 any_pend;
   logic                 ack_wr;
   logic [N_SRC-1:1]     live_evt;
   assign any_pend = ((latched & src_en[N_SRC-1:1]) != '0) || (src_en[0] && (gpio_flag_i != '0));
   assign ack_wr   = reg_wr && (reg_addr == ADDR_W'(8'h44));
   assign live_evt = src_evt_i & src_en[N_SRC-1:1];

   AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_wr |=> ((latched & $past(live_evt)) == $past(live_evt)));          // R3

   AST_DISABLED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((latched & ~$past(src_en[N_SRC-1:1])) == '0));                // R4

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ack_wr |=> ((latched & $past(reg_wdata[N_SRC-1:1] & ~src_evt_i)) == '0)); // R5

   AST_EVENT_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ack_wr |=> ((latched & $past(live_evt)) == $past(live_evt)));           // R7

   AST_PIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pin_oe_o |-> (irq_pin_o == (pin_cfg[1] ? any_pend : !any_pend)));   // R8

   AST_PUSH_PULL_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      pin_cfg[0] |-> irq_pin_oe_o);                                           // R9

   AST_OPEN_DRAIN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (!pin_cfg[0] && !any_pend) |-> !irq_pin_oe_o);                          // R9

endmodule

bind irq_hub irq_hub_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SRC(N_SRC), .GPIO_BANKS(GPIO_BANKS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .src_evt_i(src_evt_i), .gpio_flag_i(gpio_flag_i),
   .src_en(src_en), .pin_cfg(pin_cfg), .latched(latched),
   .irq_pin_o(irq_pin_o), .irq_pin_oe_o(irq_pin_oe_o)
);

// File: tb/sim_irq_hub.sv
`timescale 1ns/1ps
module sim_irq_hub;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = 8'h00;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;
   logic [7:1]  src_evt_i = '0;
   logic [23:0] gpio_flag_i = '0;
   logic        irq_pin_o, irq_pin_oe_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   irq_hub u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_evt_i(src_evt_i),
      .gpio_flag_i(gpio_flag_i), .irq_pin_o(irq_pin_o), .irq_pin_oe_o(irq_pin_oe_o)
   );

   // ---------------- behavioural reference model ----------------
   logic [7:0] m_en, m_lat;
   logic [1:0] m_cfg;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en = 0; m_lat = 0; m_cfg = 0;
      end else begin
         for (int k = 1; k < 8; k++) begin
            if (!m_en[k])                                   m_lat[k] = 1'b0;
            else if (src_evt_i[k])                          m_lat[k] = 1'b1;
            else if (reg_wr && reg_addr == 8'h44 && reg_wdata[k]) m_lat[k] = 1'b0;
         end
         if (reg_wr && reg_addr == 8'h41) m_cfg = reg_wdata[1:0];
         if (reg_wr && reg_addr == 8'h42) m_en  = reg_wdata;
      end
   end

   function automatic logic [7:0] m_pend();
      logic [7:0] p;
      p = m_lat & m_en;
      p[0] = m_en[0] && (gpio_flag_i != 0);
      return p;
   endfunction

   function automatic logic [7:0] m_read(input logic [7:0] a);
      case (a)
         8'h08: return m_pend();
         8'h0C: return gpio_flag_i[7:0];
         8'h0D: return gpio_flag_i[15:8];
         8'h0E: return gpio_flag_i[23:16];
         8'h41: return {6'b0, m_cfg};
         8'h42: return m_en;
         default: return 8'h00;
      endcase
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
      end
   endtask

   // per-cycle comparison at the falling edge
   always @(negedge clk) begin
      if (!done) begin
         logic act;
         act = (m_pend() != 0);
         chk("R8", {7'b0, irq_pin_o}, {7'b0, m_cfg[1] ? act : !act});
         chk("R9", {7'b0, irq_pin_oe_o}, {7'b0, m_cfg[0] | act});
         case (reg_addr)
            8'h08:               chk("R3", reg_rdata, m_read(reg_addr));
            8'h0C, 8'h0D, 8'h0E: chk("R6", reg_rdata, m_read(reg_addr));
            8'h44:               chk("R5", reg_rdata, m_read(reg_addr));
            default:             chk("R2", reg_rdata, m_read(reg_addr));
         endcase
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic edge_drive();
      @(posedge clk); #2;
      reg_wr = 1'b0; src_evt_i = '0;
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
      edge_drive();
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
   endtask

   task automatic fire(input logic [7:1] e);
      edge_drive();
      src_evt_i = e;
   endtask

   task automatic look(input logic [7:0] a);
      edge_drive();
      reg_addr = a;
      #1;
   endtask

   // ---------------- directed and random sequence ----------------
   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk("R1", {7'b0, irq_pin_oe_o}, 8'h00);
      rst_n = 1'b1;
      look(8'h42); chk("R1", reg_rdata, 8'h00);
      look(8'h41); chk("R1", reg_rdata, 8'h00);
      look(8'h08); chk("R1", reg_rdata, 8'h00);

      // enable all, push-pull active-high
      wr_reg(8'h42, 8'hFF);
      wr_reg(8'h41, 8'hFF);
      look(8'h41); chk("R2", reg_rdata, 8'h03);
      look(8'h44); chk("R2", reg_rdata, 8'h00);
      look(8'h77); chk("R2", reg_rdata, 8'h00);
      wr_reg(8'h77, 8'hAA);
      look(8'h42); chk("R2", reg_rdata, 8'hFF);

      // R3: event on source 3
      fire(7'b0000100);
      look(8'h08); chk("R3", reg_rdata, 8'h08);
      chk("R8", {7'b0, irq_pin_o}, 8'h01);
      look(8'h08); chk("R3", reg_rdata, 8'h08);

      // R10: write to pending address ignored
      wr_reg(8'h08, 8'h00);
      look(8'h08); chk("R10", reg_rdata, 8'h08);

      // R5: acknowledge with zero bits keeps, with one bit clears
      wr_reg(8'h44, 8'hF7);
      look(8'h08); chk("R5", reg_rdata, 8'h08);
      wr_reg(8'h44, 8'h08);
      look(8'h08); chk("R5", reg_rdata, 8'h00);
      chk("R8", {7'b0, irq_pin_o}, 8'h00);
      chk("R9", {7'b0, irq_pin_oe_o}, 8'h01);

      // R7: event and acknowledge together on source 2
      fire(7'b0000010);
      wr_reg(8'h44, 8'h04);
      src_evt_i = 7'b0000010;
      look(8'h08); chk("R7", reg_rdata, 8'h04);
      wr_reg(8'h44, 8'h04);
      look(8'h08); chk("R7", reg_rdata, 8'h00);

      // R4: disabled source ignored; disabling drops a latched flag
      wr_reg(8'h42, 8'hDF);
      fire(7'b0010000);
      look(8'h08); chk("R4", reg_rdata, 8'h00);
      fire(7'b1000000);
      look(8'h08); chk("R4", reg_rdata, 8'h80);
      wr_reg(8'h42, 8'h7F);
      look(8'h08); chk("R4", reg_rdata, 8'h00);
      wr_reg(8'h42, 8'hFF);
      look(8'h08); chk("R4", reg_rdata, 8'h00);

      // R6: live source from the flag banks, immune to acknowledge
      edge_drive(); gpio_flag_i = 24'h020000; reg_addr = 8'h08; #1;
      chk("R6", reg_rdata, 8'h01);
      look(8'h0E); chk("R6", reg_rdata, 8'h02);
      wr_reg(8'h44, 8'hFF);
      look(8'h08); chk("R6", reg_rdata, 8'h01);
      edge_drive(); gpio_flag_i = 24'h0; reg_addr = 8'h08; #1;
      chk("R6", reg_rdata, 8'h00);

      // R8/R9 open-drain active-low
      wr_reg(8'h41, 8'h00);
      look(8'h08);
      chk("R9", {7'b0, irq_pin_oe_o}, 8'h00);
      fire(7'b0000001);
      look(8'h08); chk("R3", reg_rdata, 8'h02);
      chk("R8", {7'b0, irq_pin_o}, 8'h00);
      chk("R9", {7'b0, irq_pin_oe_o}, 8'h01);
      wr_reg(8'h41, 8'h02);
      look(8'h08); chk("R8", {7'b0, irq_pin_o}, 8'h01);

      // random phase, compared every cycle against the model
      for (int i = 0; i < 600; i++) begin
         logic [7:0] pick;
         edge_drive();
         pick = 8'($urandom);
         src_evt_i   = 7'($urandom) & 7'($urandom);
         if (pick[2:0] == 3'd0) gpio_flag_i = ($urandom % 4 == 0) ? 24'($urandom) : 24'h0;
         case (pick[7:5])
            3'd0: begin reg_wr = 1'b1; reg_addr = 8'h44; reg_wdata = 8'($urandom); end
            3'd1: begin reg_wr = 1'b1; reg_addr = 8'h42; reg_wdata = 8'($urandom); end
            3'd2: begin reg_wr = 1'b1; reg_addr = 8'h41; reg_wdata = 8'($urandom); end
            3'd3: begin reg_wr = 1'b1; reg_addr = 8'h08; reg_wdata = 8'($urandom); end
            3'd4: reg_addr = 8'h0C + 8'(pick[1:0]);
            default: reg_addr = 8'h08;
         endcase
      end

      edge_drive();
      @(posedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #200_000;
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule